// File: doc/BRIEF.md
# SPI FIFO and Interrupt Status Unit

This block is the register-side half of one SPI channel. It stands between a 32-bit register bus and the serial shifting engine. It holds a transmit queue and a receive queue of 32-bit words. Software loads outgoing words into the transmit queue and then writes the command register to start a transfer. While the transfer runs, the engine drains the transmit queue and fills the receive queue, and software collects the received words over the bus.

The unit turns queue activity into sticky event flags in a status register. Software clears these flags by writing ones. The unit raises a single interrupt line whenever a flag that software has enabled is set. Two threshold nibbles let software choose when it is told that the transmit queue is running low or that the receive queue is filling up. Each channel of a multi-channel controller gets its own instance, decoded on the low six address bits of its 0x40-byte bank.

Top module: `spi_fifo_status_unit`

## Requirements
- R1: Each queue holds up to 8 words of 32 bits and returns words in the order they were written. `eng_tx_data` shows the oldest transmit word.
- R2: Reading offset 0x18 returns the receive word count in bits [3:0] and the transmit word count in bits [7:4]. All other bits read as zero.
- R3: Reading offset 0x0C returns the status flags: bit 0 busy, bit 1 done, bit 2 transmit-low, bit 3 receive-high, bit 4 transmit underflow, bit 5 receive overflow. Bits above 5 read as zero.
- R4: A write to offset 0x0C clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. If a bit is set by an event in the same cycle, the set takes priority.
- R5: A write to offset 0x08 sets busy (`xfer_active`). A pulse on `eng_done` clears busy and sets done. If a command write and `eng_done` fall in the same cycle, busy stays set.
- R6: Offset 0x14 holds the thresholds: the transmit-low level in [3:0] and the receive-high level in [7:4]. Its reset value is 0x80. While busy, transmit-low sets when the transmit count is at or below the low level, and receive-high sets when the receive count is at or above the high level. While not busy, neither flag sets.
- R7: A pulse on `eng_tx_pop` while the transmit queue is empty sets transmit underflow and changes nothing else. A pulse on `eng_rx_push` while the receive queue is full sets receive overflow and drops the word.
- R8: Offset 0x10 holds the enables: bit 0 done, bit 1 transmit-low, bit 2 receive-high, bit 3 transmit underflow, bit 4 receive overflow. `irq` is the OR of the enabled flags, registered one cycle after the status. Busy never raises `irq`.
- R9: A write to offset 0x1C while the transmit queue is full is ignored. A read of offset 0x20 while the receive queue is empty returns zero and leaves the count unchanged.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and is zero in any cycle that follows no read. Offsets that are not mapped, and the write-only command offset, read as zero.
- R11: After reset, both counts, the status, the enables, `irq` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset within the channel bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| xfer_active | output | 1 | Busy flag, high while a transfer runs |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_done | input | 1 | Engine reports the transfer finished |

## Verification
The assertions assume single-cycle strobes that are sampled on every edge. They do not assume that the engine respects the queue levels: an engine that pops an empty queue or pushes into a full one is legal, and the flags record these events. The stimulus drives every strobe on the falling edge. It deliberately pops the empty transmit queue and overfills the receive queue, so that the underflow and overflow paths are reached inside the assumed protocol. It also clears flags while their setting condition still holds.

// File: rtl/sfsu_pkg.sv
package sfsu_pkg;

  // channel bank spans 0x40 bytes, so six offset bits
  localparam int BANK_AW = 6;

  localparam logic [BANK_AW-1:0] OFS_CMD    = 6'h08;
  localparam logic [BANK_AW-1:0] OFS_STAT   = 6'h0C;
  localparam logic [BANK_AW-1:0] OFS_INTEN  = 6'h10;
  localparam logic [BANK_AW-1:0] OFS_THRESH = 6'h14;
  localparam logic [BANK_AW-1:0] OFS_LEVEL  = 6'h18;
  localparam logic [BANK_AW-1:0] OFS_TXD    = 6'h1C;
  localparam logic [BANK_AW-1:0] OFS_RXD    = 6'h20;

  localparam int ST_W  = 6;   // status flags
  localparam int EN_W  = 5;   // enables gate status bits [5:1]
  localparam int NIB_W = 4;   // packed count / threshold field width

  localparam int SB_BUSY = 0;

  // event vector; field order places busy at bit 0
  typedef struct packed {
    logic rx_over;
    logic tx_under;
    logic rx_high;
    logic tx_low;
    logic done;
    logic busy;
  } evt_t;

endpackage

// File: rtl/sfsu_fifo.sv
module sfsu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + PW'(1);
  endfunction

  // full and empty are judged on the count before this edge
  assign push_ok = push && (int'(cnt_q) != DEPTH);
  assign pop_ok  = pop  && (cnt_q != '0);

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;

endmodule

// File: rtl/sfsu_events.sv
module sfsu_events
  import sfsu_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             eng_done,
  input  logic [ST_W-1:0]  stat_clr,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [NIB_W-1:0] thr_tx,
  input  logic [NIB_W-1:0] thr_rx,
  input  logic [EN_W-1:0]  inten,
  input  logic             tx_under,
  input  logic             rx_over,
  output logic [ST_W-1:0]  status,
  output logic             irq
);

  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] clr_mask;
  evt_t            evt;
  logic            irq_q;

  always_comb begin
    evt          = '0;
    evt.busy     = cmd_wr;
    evt.done     = eng_done;
    evt.tx_low   = status_q[SB_BUSY] && (int'(tx_cnt) <= int'(thr_tx));
    evt.rx_high  = status_q[SB_BUSY] && (int'(rx_cnt) >= int'(thr_rx));
    evt.tx_under = tx_under;
    evt.rx_over  = rx_over;
  end

  // engine completion retires busy; software clears by writing ones
  assign clr_mask = stat_clr | ST_W'(eng_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt;
      irq_q    <= |(status_q[ST_W-1:1] & inten);
    end
  end

  assign status = status_q;
  assign irq    = irq_q;

endmodule

// File: rtl/sfsu_bus_regs.sv
module sfsu_bus_regs
  import sfsu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CW         = 4,
  parameter logic [7:0] THR_RST = 8'h80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BANK_AW-1:0] bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic [CW-1:0]      tx_cnt,
  input  logic [CW-1:0]      rx_cnt,
  input  logic [DW-1:0]      rx_head,
  input  logic [ST_W-1:0]    status,
  output logic [EN_W-1:0]    inten,
  output logic [NIB_W-1:0]   thr_tx,
  output logic [NIB_W-1:0]   thr_rx,
  output logic               tx_push,
  output logic               rx_pop,
  output logic               cmd_wr,
  output logic [ST_W-1:0]    stat_clr,
  output logic [DW-1:0]      bus_rdata
);

  logic [EN_W-1:0]    inten_q;
  logic [2*NIB_W-1:0] thr_q;
  logic [DW-1:0]      rd_mux;
  logic [DW-1:0]      rdata_q;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata[DW-1:2*NIB_W];

  assign tx_push  = bus_wr && (bus_addr == OFS_TXD);
  assign cmd_wr   = bus_wr && (bus_addr == OFS_CMD);
  assign rx_pop   = bus_rd && (bus_addr == OFS_RXD);
  assign stat_clr = (bus_wr && (bus_addr == OFS_STAT)) ? bus_wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      inten_q <= '0;
      thr_q   <= THR_RST;
    end else if (bus_wr) begin
      if (bus_addr == OFS_INTEN)  inten_q <= bus_wdata[EN_W-1:0];
      if (bus_addr == OFS_THRESH) thr_q   <= bus_wdata[2*NIB_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      OFS_STAT:   rd_mux = DW'(status);
      OFS_INTEN:  rd_mux = DW'(inten_q);
      OFS_THRESH: rd_mux = DW'(thr_q);
      OFS_LEVEL:  rd_mux = DW'({NIB_W'(tx_cnt), NIB_W'(rx_cnt)});
      OFS_RXD:    rd_mux = (rx_cnt != '0) ? rx_head : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign inten     = inten_q;
  assign thr_tx    = thr_q[NIB_W-1:0];
  assign thr_rx    = thr_q[2*NIB_W-1:NIB_W];
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/spi_fifo_status_unit.sv
module spi_fifo_status_unit
  import sfsu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 8,
  parameter logic [7:0] THR_RST = 8'h80,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BANK_AW-1:0] bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq,
  output logic               xfer_active,
  input  logic               eng_tx_pop,
  output logic [DW-1:0]      eng_tx_data,
  input  logic               eng_rx_push,
  input  logic [DW-1:0]      eng_rx_data,
  input  logic               eng_done
);

  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [DW-1:0]    rx_head;
  logic [ST_W-1:0]  status_q;
  logic [EN_W-1:0]  inten_q;
  logic [NIB_W-1:0] thr_tx, thr_rx;
  logic             tx_push, rx_pop, cmd_wr;
  logic [ST_W-1:0]  stat_clr;
  logic             tx_under, rx_over;

  assign tx_under = eng_tx_pop  && (tx_cnt == '0);
  assign rx_over  = eng_rx_push && (int'(rx_cnt) == FIFO_DEPTH);

  sfsu_bus_regs #(.DW(DW), .CW(CW), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_head(rx_head), .status(status_q),
    .inten(inten_q), .thr_tx(thr_tx), .thr_rx(thr_rx),
    .tx_push(tx_push), .rx_pop(rx_pop), .cmd_wr(cmd_wr), .stat_clr(stat_clr),
    .bus_rdata(bus_rdata)
  );

  sfsu_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .push_data(bus_wdata),
    .pop(eng_tx_pop), .head(eng_tx_data), .count(tx_cnt)
  );

  sfsu_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt)
  );

  sfsu_events #(.CW(CW)) u_evt (
    .clk(clk), .rst(rst),
    .cmd_wr(cmd_wr), .eng_done(eng_done), .stat_clr(stat_clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .thr_tx(thr_tx), .thr_rx(thr_rx),
    .inten(inten_q), .tx_under(tx_under), .rx_over(rx_over),
    .status(status_q), .irq(irq)
  );

  assign xfer_active = status_q[SB_BUSY];

endmodule

// File: rtl/sfsu_checker.sv
module sfsu_checker
  import sfsu_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int FIFO_DEPTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [BANK_AW-1:0] bus_addr,
  input logic [DW-1:0]      bus_rdata,
  input logic               irq,
  input logic               xfer_active,
  input logic               eng_tx_pop,
  input logic               eng_rx_push,
  input logic               eng_done,
  input logic [CW-1:0]      tx_cnt,
  input logic [CW-1:0]      rx_cnt,
  input logic [ST_W-1:0]    status_q,
  input logic [EN_W-1:0]    inten_q
);

  always @(posedge clk) begin
    if (!rst) begin
      AST_COUNT_BOUND: assert (int'(tx_cnt) <= FIFO_DEPTH && int'(rx_cnt) <= FIFO_DEPTH); // R1
    end
  end

  AST_TX_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == OFS_TXD && int'(tx_cnt) == FIFO_DEPTH && !eng_tx_pop
    |=> int'(tx_cnt) == FIFO_DEPTH); // R9

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == OFS_RXD && rx_cnt == '0 |=> bus_rdata == '0); // R9

  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == OFS_CMD |=> xfer_active); // R5

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> status_q[1]); // R5

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    eng_tx_pop && tx_cnt == '0 |=> status_q[4] && tx_cnt == '0 || bus_wr); // R7

  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    eng_rx_push && int'(rx_cnt) == FIFO_DEPTH |=> status_q[5]); // R7

  AST_NO_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (status_q[ST_W-1:1] & inten_q) == '0 |=> !irq); // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R10

endmodule

bind spi_fifo_status_unit sfsu_checker #(.DW(DW), .CW(CW), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .xfer_active(xfer_active),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_done(eng_done),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .status_q(status_q), .inten_q(inten_q)
);

// File: tb/spi_fifo_status_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_status_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, xfer_active;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
  logic [31:0] eng_tx_data;
  logic [31:0] eng_rx_data = '0;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  spi_fifo_status_unit uut (.*);

  // ---------------- behavioural reference ----------------
  logic [31:0] mtx[$];
  logic [31:0] mrx[$];
  logic [5:0]  mst;
  logic [4:0]  men;
  logic [7:0]  mthr;
  logic        mirq;
  logic [31:0] mrd;

  always @(posedge clk) begin : ref_model
    int txc, rxc;
    logic [5:0] so, setv, clr;
    logic [4:0] eo;
    if (rst) begin
      mtx.delete(); mrx.delete();
      mst = '0; men = '0; mthr = 8'h80; mirq = 1'b0; mrd = '0;
    end else begin
      txc = mtx.size(); rxc = mrx.size(); so = mst; eo = men;
      mrd = '0;
      if (bus_rd) begin
        case (bus_addr)
          6'h0C: mrd = 32'(so);
          6'h10: mrd = 32'(eo);
          6'h14: mrd = 32'(mthr);
          6'h18: mrd = 32'(txc * 16 + rxc);
          6'h20: mrd = (rxc > 0) ? mrx[0] : 32'h0;
          default: mrd = '0;
        endcase
      end
      setv = '0;
      if (bus_wr && bus_addr == 6'h08) setv[0] = 1'b1;
      if (eng_done) setv[1] = 1'b1;
      if (so[0] && txc <= int'(mthr[3:0])) setv[2] = 1'b1;
      if (so[0] && rxc >= int'(mthr[7:4])) setv[3] = 1'b1;
      if (eng_tx_pop && txc == 0) setv[4] = 1'b1;
      if (eng_rx_push && rxc == 8) setv[5] = 1'b1;
      clr = (bus_wr && bus_addr == 6'h0C) ? bus_wdata[5:0] : 6'h0;
      if (eng_done) clr[0] = 1'b1;
      mst  = (so & ~clr) | setv;
      mirq = |(so[5:1] & eo);
      if (bus_wr && bus_addr == 6'h10) men  = bus_wdata[4:0];
      if (bus_wr && bus_addr == 6'h14) mthr = bus_wdata[7:0];
      if (eng_tx_pop && txc > 0) void'(mtx.pop_front());
      if (bus_wr && bus_addr == 6'h1C && txc < 8) mtx.push_back(bus_wdata);
      if (bus_rd && bus_addr == 6'h20 && rxc > 0) void'(mrx.pop_front());
      if (eng_rx_push && rxc < 8) mrx.push_back(eng_rx_data);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      check("R10 rdata vs model", bus_rdata, mrd);
      check("R8 irq vs model", 32'(irq), 32'(mirq));
      check("R5 xfer_active vs model", 32'(xfer_active), 32'(mst[0]));
      if (mtx.size() > 0) check("R1 tx head vs model", eng_tx_data, mtx[0]);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [5:0] a, input logic [31:0] mask,
                          input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    check(tag, bus_rdata & mask, exp);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    tick(3);
    rst = 1'b0;

    // R11 reset state
    rd_check(6'h18, 32'hFFFF_FFFF, 32'h0, "R11 level after reset");
    rd_check(6'h0C, 32'hFFFF_FFFF, 32'h0, "R11 status after reset");
    rd_check(6'h10, 32'hFFFF_FFFF, 32'h0, "R11 enables after reset");
    rd_check(6'h14, 32'hFFFF_FFFF, 32'h80, "R6 threshold reset value");
    check("R11 irq after reset", 32'(irq), 32'h0);

    // R2 packed counts, R1 head
    for (int i = 0; i < 3; i++) wr(6'h1C, 32'hA000_0000 + i);
    rd_check(6'h18, 32'hFFFF_FFFF, 32'h30, "R2 level three tx words");
    check("R1 tx head first word", eng_tx_data, 32'hA000_0000);
    for (int i = 3; i < 9; i++) wr(6'h1C, 32'hA000_0000 + i);
    rd_check(6'h18, 32'hFFFF_FFFF, 32'h80, "R9 ninth tx write ignored");

    // thresholds and enables, then start
    wr(6'h14, 32'h42);
    wr(6'h10, 32'h1F);
    rd_check(6'h0C, 32'h3F, 32'h0, "R6 no events while idle");
    wr(6'h08, 32'h0);
    rd_check(6'h0C, 32'h3F, 32'h01, "R5 R3 busy after command");

    for (int k = 0; k < 6; k++) begin
      check("R1 tx order", eng_tx_data, 32'hA000_0000 + k);
      eng_tx_pop = 1'b1; tick(); eng_tx_pop = 1'b0;
    end
    tick();
    rd_check(6'h0C, 32'h04, 32'h04, "R6 R3 tx-low at threshold");
    tick();
    check("R8 irq from tx-low", 32'(irq), 32'h1);

    wr(6'h0C, 32'h04);
    rd_check(6'h0C, 32'h04, 32'h04, "R4 set wins over clear");

    for (int k = 0; k < 3; k++) begin
      eng_tx_pop = 1'b1; tick(); eng_tx_pop = 1'b0;
    end
    rd_check(6'h0C, 32'h10, 32'h10, "R7 R3 tx underflow flag");
    rd_check(6'h18, 32'hF0, 32'h00, "R7 underflow leaves tx count");

    for (int k = 0; k < 9; k++) begin
      eng_rx_push = 1'b1; eng_rx_data = 32'hB000_0000 + k; tick();
    end
    eng_rx_push = 1'b0;
    rd_check(6'h18, 32'hFFFF_FFFF, 32'h08, "R2 level full rx");
    rd_check(6'h0C, 32'h28, 32'h28, "R7 R6 overflow and rx-high");

    eng_done = 1'b1; tick(); eng_done = 1'b0;
    rd_check(6'h0C, 32'h03, 32'h02, "R5 done clears busy");

    for (int k = 0; k < 8; k++)
      rd_check(6'h20, 32'hFFFF_FFFF, 32'hB000_0000 + k, "R1 rx order");
    rd_check(6'h20, 32'hFFFF_FFFF, 32'h0, "R9 empty rx read is zero");
    rd_check(6'h18, 32'hFFFF_FFFF, 32'h0, "R9 empty read keeps count");

    wr(6'h0C, 32'h0);
    rd_check(6'h0C, 32'hFFFF_FFFF, 32'h3E, "R4 zero write keeps flags");
    wr(6'h0C, 32'h3F);
    rd_check(6'h0C, 32'hFFFF_FFFF, 32'h0, "R4 R6 clear while idle");
    tick(2);
    check("R8 irq low with no flags", 32'(irq), 32'h0);

    wr(6'h10, 32'h01);
    wr(6'h08, 32'h0);
    tick(2);
    rd_check(6'h0C, 32'h3F, 32'h05, "R6 busy and tx-low");
    tick();
    check("R8 busy never raises irq", 32'(irq), 32'h0);
    wr(6'h10, 32'h02);
    tick(2);
    check("R8 tx-low enable raises irq", 32'(irq), 32'h1);
    rd_check(6'h10, 32'hFFFF_FFFF, 32'h02, "R8 enable readback");
    rd_check(6'h04, 32'hFFFF_FFFF, 32'h0, "R10 unmapped offset");
    rd_check(6'h08, 32'hFFFF_FFFF, 32'h0, "R10 command reads zero");

    eng_done = 1'b1; tick(); eng_done = 1'b0;
    tick(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule